// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the strobes that an 8051-style core needs to reach external code and data memory over a multiplexed bus. It splits every machine cycle into six equal slots. Each slot lasts two oscillator clocks in normal mode and one clock in double-speed mode. From these slots it drives the address-latch strobe, the program-store read strobe, the data read and write strobes, the select for the low-byte address/data mux, and the byte shown on the high-address port.

Each half of a machine cycle fetches code from the current program counter. The fetch is internal or external, depending on the external-access input and the address. An external data request turns the next machine cycle into a data cycle, in which the data address goes out and a read or write strobe replaces the code strobes. A control input can hold the address-latch strobe low whenever the bus has nothing external to latch.

Top module: `bus_strobe_seq`

## Requirements
- R1: While reset is low, the sequencer sits in slot 0 of a normal-mode fetch cycle whose fetch is taken as internal. psen_n_o, rd_n_o and wr_n_o are 1, p0_addr_sel_o is 0 and p2_o equals p2_sfr_i.
- R2: A machine cycle has six slots numbered 0 to 5. A slot lasts 2 clocks when the mode latched at the last cycle boundary is normal and 1 clock when it is double-speed. x2_i is sampled on the clock that ends slot 5. In a fetch cycle ale_o is 1 for the whole of slots 0 and 3. With nothing suppressed, ale_o therefore rises once every 6 clocks in normal mode and once every 3 clocks in double-speed mode.
- R3: A half-cycle's fetch is external when ea_i is 0 or pc_i is 0x2000 or above, and internal otherwise. The decision and the fetch address come from pc_i and ea_i on the clock that enters slot 0 or slot 3.
- R4: In a fetch cycle psen_n_o is 0 for the whole of slot 1 when the first half's fetch is external, and for the whole of slot 4 when the second half's fetch is external. It is 1 at all other times, and never 0 for an internal fetch.
- R5: While ale_off_i is 1, ale_o stays 0 in fetch half-cycles whose fetch is internal. It still pulses for external fetch half-cycles and in slot 0 of data cycles.
- R6: xd_req_i is sampled on the clock that ends slot 5 of a fetch cycle. When it is 1, the next machine cycle is a data cycle, and xd_addr_i, xd_wide_i and xd_wr_i are latched for it. A request present at the end of a data cycle is ignored, and the next cycle is a fetch cycle.
- R7: In a data cycle ale_o is 1 only in slot 0, so the slot-3 pulse is omitted. psen_n_o stays 1 through the whole cycle. In slots 1 to 4, rd_n_o is 0 for a read (xd_wr_i=0) and wr_n_o is 0 for a write (xd_wr_i=1). The two are never 0 together.
- R8: p2_o carries bits 15:8 of the fetch address during an external fetch half-cycle, and bits 15:8 of the data address in a data cycle with xd_wide_i=1. In every other case, including a data cycle with xd_wide_i=0, p2_o equals p2_sfr_i.
- R9: p0_addr_sel_o is 1 only in slots 0 and 3 of external fetch half-cycles and in slot 0 of a data cycle. p0_addr_o carries bits 7:0 of the address latched for the current half-cycle or data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_i | input | 1 | Double-speed mode select, sampled at cycle boundary |
| ea_i | input | 1 | External-access level; 0 forces every fetch external |
| ale_off_i | input | 1 | Suppress address-latch strobe during internal fetches |
| pc_i | input | 16 | Current program counter |
| xd_req_i | input | 1 | External data access request |
| xd_wide_i | input | 1 | 1: 16-bit pointer access, 0: 8-bit register-indirect |
| xd_wr_i | input | 1 | 1: write, 0: read |
| xd_addr_i | input | 16 | External data address |
| p2_sfr_i | input | 8 | Port-2 register contents |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p2_o | output | 8 | High-address port byte |
| p0_addr_sel_o | output | 1 | Low port drives address (1) or data (0) |
| p0_addr_o | output | 8 | Low address byte for the multiplexed port |

## Verification
The bench runs a clock-by-clock reference model. Its random stimulus keeps pc_i close to the 0x1FFF/0x2000 boundary and toggles ea_i, ale_off_i and the mode while data requests arrive. A design that decides internal against external with an off-by-one limit would pulse psen_n_o at 0x1FFF. A design that changes slot length in the middle of a cycle after a mode switch would shift every later strobe.

Directed windows count edges. Held requests must give strictly alternating fetch and data cycles, so five read strobes in ten cycles. A design that accepts a request at the end of a data cycle would produce more strobes and lose the code-strobe count. A design that skipped the wrong ALE or PSEN pulse in the data cycle would miscount the ALE edges in the same window.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int SLOTS_PER_CYCLE = 6;

    typedef enum logic [2:0] {
        SL_0 = 3'd0,
        SL_1 = 3'd1,
        SL_2 = 3'd2,
        SL_3 = 3'd3,
        SL_4 = 3'd4,
        SL_5 = 3'd5
    } slot_e;

    typedef enum logic {
        CK_FETCH = 1'b0,
        CK_DATA  = 1'b1
    } kind_e;

    typedef struct packed {
        slot_e slot;
        logic  half;
        logic  x2;
    } phase_t;

    function automatic slot_e slot_after(slot_e s);
        slot_e r;
        case (s)
            SL_0:    r = SL_1;
            SL_1:    r = SL_2;
            SL_2:    r = SL_3;
            SL_3:    r = SL_4;
            SL_4:    r = SL_5;
            default: r = SL_0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bus_phase_gen.sv
module bus_phase_gen
    import bus_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  x2_i,
    output slot_e slot_o,
    output logic  tick_o,
    output logic  last_o,
    output logic  mid_o
);

    phase_t ph_d, ph_q;
    logic   tick;

    always_comb begin
        ph_d  = ph_q;
        tick  = ph_q.x2 ? 1'b1 : ph_q.half;
        ph_d.half = ph_q.x2 ? 1'b0 : ~ph_q.half;
        if (tick) begin
            ph_d.slot = slot_after(ph_q.slot);
        end
        if (tick && ph_q.slot == SL_5) begin
            ph_d.x2 = x2_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '{slot: SL_0, half: 1'b0, x2: 1'b0};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign slot_o = ph_q.slot;
    assign tick_o = tick;
    assign last_o = tick && (ph_q.slot == SL_5);
    assign mid_o  = tick && (ph_q.slot == SL_2);

    // R2: the slot stays inside the six legal values
    a_r2_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.slot inside {SL_0, SL_1, SL_2, SL_3, SL_4, SL_5});

    // R2: the slot only ever steps forward by one, wrapping after slot 5
    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q.slot != $past(ph_q.slot)) |-> (ph_q.slot == slot_after($past(ph_q.slot))));

    // R2: double-speed mode never leaves a half-slot pending
    a_r2_x2_no_half: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.x2 |-> !ph_q.half);

    // R2: the mode changes only when a new cycle starts
    a_r2_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q.x2 != $past(ph_q.x2)) |-> (ph_q.slot == SL_0));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bus_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int INT_BYTES = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         slot_i,
    input  logic          last_i,
    input  logic          mid_i,
    input  logic          ea_i,
    input  logic [AW-1:0] pc_i,
    input  logic          xd_req_i,
    input  logic          xd_wide_i,
    input  logic          xd_wr_i,
    input  logic [AW-1:0] xd_addr_i,
    output kind_e         kind_o,
    output logic          fext_o,
    output logic [AW-1:0] faddr_o,
    output logic [AW-1:0] xaddr_o,
    output logic          xwide_o,
    output logic          xwr_o
);

    localparam logic [AW:0] INT_LIMIT = (AW+1)'(INT_BYTES);

    typedef struct packed {
        kind_e         kind;
        logic          fext;
        logic [AW-1:0] faddr;
        logic [AW-1:0] xaddr;
        logic          xwide;
        logic          xwr;
    } ctl_t;

    ctl_t c_d, c_q;
    logic ext_now;

    always_comb begin
        c_d     = c_q;
        ext_now = !ea_i || ({1'b0, pc_i} >= INT_LIMIT);
        if (last_i || mid_i) begin
            c_d.fext  = ext_now;
            c_d.faddr = pc_i;
        end
        if (last_i) begin
            if (c_q.kind == CK_FETCH && xd_req_i) begin
                c_d.kind  = CK_DATA;
                c_d.xaddr = xd_addr_i;
                c_d.xwide = xd_wide_i;
                c_d.xwr   = xd_wr_i;
            end else begin
                c_d.kind  = CK_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{kind: CK_FETCH, fext: 1'b0, faddr: '0, xaddr: '0,
                     xwide: 1'b0, xwr: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign kind_o  = c_q.kind;
    assign fext_o  = c_q.fext;
    assign faddr_o = c_q.faddr;
    assign xaddr_o = c_q.xaddr;
    assign xwide_o = c_q.xwide;
    assign xwr_o   = c_q.xwr;

    // R6: the cycle kind only changes as a new machine cycle begins
    a_r6_kind_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.kind != $past(c_q.kind)) |-> (slot_i == SL_0));

    // R6: two data cycles never follow one another
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.kind == CK_DATA && slot_i == SL_0 && $past(slot_i) == SL_5)
            |-> ($past(c_q.kind) == CK_FETCH));

endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
    import bus_seq_pkg::*;
#(
    parameter  int AW = 16,
    localparam int HW = AW - 8
) (
    input  slot_e         slot_i,
    input  kind_e         kind_i,
    input  logic          fext_i,
    input  logic [AW-1:0] faddr_i,
    input  logic [AW-1:0] xaddr_i,
    input  logic          xwide_i,
    input  logic          xwr_i,
    input  logic          ale_off_i,
    input  logic [HW-1:0] p2_sfr_i,
    output logic          ale_o,
    output logic          psen_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [HW-1:0] p2_o,
    output logic          p0_sel_o,
    output logic [7:0]    p0_addr_o
);

    logic latch_slot;
    logic code_slot;
    logic strobe_slot;

    always_comb begin
        latch_slot  = (slot_i == SL_0) || (slot_i == SL_3);
        code_slot   = (slot_i == SL_1) || (slot_i == SL_4);
        strobe_slot = (slot_i != SL_0) && (slot_i != SL_5);

        ale_o     = 1'b0;
        psen_n_o  = 1'b1;
        rd_n_o    = 1'b1;
        wr_n_o    = 1'b1;
        p2_o      = p2_sfr_i;
        p0_sel_o  = 1'b0;
        p0_addr_o = faddr_i[7:0];

        if (kind_i == CK_DATA) begin
            ale_o     = (slot_i == SL_0);
            p0_sel_o  = (slot_i == SL_0);
            p0_addr_o = xaddr_i[7:0];
            rd_n_o    = !(strobe_slot && !xwr_i);
            wr_n_o    = !(strobe_slot && xwr_i);
            if (xwide_i) begin
                p2_o = xaddr_i[AW-1:8];
            end
        end else begin
            ale_o    = latch_slot && (fext_i || !ale_off_i);
            psen_n_o = !(code_slot && fext_i);
            p0_sel_o = latch_slot && fext_i;
            if (fext_i) begin
                p2_o = faddr_i[AW-1:8];
            end
        end
    end

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
    import bus_seq_pkg::*;
#(
    parameter  int AW        = 16,
    parameter  int INT_BYTES = 8192,
    localparam int HW        = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x2_i,
    input  logic          ea_i,
    input  logic          ale_off_i,
    input  logic [AW-1:0] pc_i,
    input  logic          xd_req_i,
    input  logic          xd_wide_i,
    input  logic          xd_wr_i,
    input  logic [AW-1:0] xd_addr_i,
    input  logic [HW-1:0] p2_sfr_i,
    output logic          ale_o,
    output logic          psen_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [HW-1:0] p2_o,
    output logic          p0_addr_sel_o,
    output logic [7:0]    p0_addr_o
);

    slot_e         slot;
    logic          tick;
    logic          last;
    logic          mid;
    kind_e         kind;
    logic          fext;
    logic [AW-1:0] faddr;
    logic [AW-1:0] xaddr;
    logic          xwide;
    logic          xwr;

    bus_phase_gen u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .x2_i   (x2_i),
        .slot_o (slot),
        .tick_o (tick),
        .last_o (last),
        .mid_o  (mid)
    );

    bus_cycle_ctrl #(
        .AW        (AW),
        .INT_BYTES (INT_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_i    (slot),
        .last_i    (last),
        .mid_i     (mid),
        .ea_i      (ea_i),
        .pc_i      (pc_i),
        .xd_req_i  (xd_req_i),
        .xd_wide_i (xd_wide_i),
        .xd_wr_i   (xd_wr_i),
        .xd_addr_i (xd_addr_i),
        .kind_o    (kind),
        .fext_o    (fext),
        .faddr_o   (faddr),
        .xaddr_o   (xaddr),
        .xwide_o   (xwide),
        .xwr_o     (xwr)
    );

    bus_strobe_dec #(
        .AW (AW)
    ) u_dec (
        .slot_i    (slot),
        .kind_i    (kind),
        .fext_i    (fext),
        .faddr_i   (faddr),
        .xaddr_i   (xaddr),
        .xwide_i   (xwide),
        .xwr_i     (xwr),
        .ale_off_i (ale_off_i),
        .p2_sfr_i  (p2_sfr_i),
        .ale_o     (ale_o),
        .psen_n_o  (psen_n_o),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o),
        .p2_o      (p2_o),
        .p0_sel_o  (p0_addr_sel_o),
        .p0_addr_o (p0_addr_o)
    );

    // R7: code strobe and data strobes never overlap
    a_r7_no_psen_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n_o |-> (rd_n_o && wr_n_o));

    // R7: read and write strobes are mutually exclusive
    a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> wr_n_o);

    // R5: with suppression on, any ALE pulse belongs to an external access
    a_r5_ale_off_external: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_o && ale_off_i) |-> p0_addr_sel_o);

    // R9: the address phase on the low port always coincides with ALE
    a_r9_sel_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
        p0_addr_sel_o |-> ale_o);

    // R4: a code strobe only appears once the bus has left its latch slot
    a_r4_psen_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n_o) |-> !ale_o);

endmodule

// File: tb/bus_strobe_seq_test.sv
module bus_strobe_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x2 = 1'b0;
    logic        ea = 1'b1;
    logic        ale_off = 1'b0;
    logic [15:0] pc = '0;
    logic        req = 1'b0;
    logic        wide = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] xa = '0;
    logic [7:0]  sfr = 8'h5A;

    logic        ale;
    logic        psen_n;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  p2;
    logic        p0_sel;
    logic [7:0]  p0_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int          m_slot;
    bit          m_half, m_x2, m_kind, m_fext, m_xwide, m_xwr;
    logic [15:0] m_faddr, m_xaddr;

    always #10 clk = ~clk;

    bus_strobe_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .x2_i          (x2),
        .ea_i          (ea),
        .ale_off_i     (ale_off),
        .pc_i          (pc),
        .xd_req_i      (req),
        .xd_wide_i     (wide),
        .xd_wr_i       (wr),
        .xd_addr_i     (xa),
        .p2_sfr_i      (sfr),
        .ale_o         (ale),
        .psen_n_o      (psen_n),
        .rd_n_o        (rd_n),
        .wr_n_o        (wr_n),
        .p2_o          (p2),
        .p0_addr_sel_o (p0_sel),
        .p0_addr_o     (p0_addr)
    );

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit e_ale();
        if (m_kind) return (m_slot == 0);
        return (m_slot == 0 || m_slot == 3) && (m_fext || !ale_off);
    endfunction
    function automatic bit e_psen_n();
        if (m_kind) return 1'b1;
        return !((m_slot == 1 || m_slot == 4) && m_fext);
    endfunction
    function automatic bit e_rd_n();
        return !(m_kind && m_slot >= 1 && m_slot <= 4 && !m_xwr);
    endfunction
    function automatic bit e_wr_n();
        return !(m_kind && m_slot >= 1 && m_slot <= 4 && m_xwr);
    endfunction
    function automatic logic [7:0] e_p2();
        if (m_kind) return m_xwide ? m_xaddr[15:8] : sfr;
        return m_fext ? m_faddr[15:8] : sfr;
    endfunction
    function automatic bit e_sel();
        if (m_kind) return (m_slot == 0);
        return (m_slot == 0 || m_slot == 3) && m_fext;
    endfunction
    function automatic logic [7:0] e_p0();
        return m_kind ? m_xaddr[7:0] : m_faddr[7:0];
    endfunction

    task automatic model_update();
        bit tk, lst, mid, ext, nh;
        if (!rst_n) begin
            m_slot = 0; m_half = 0; m_x2 = 0; m_kind = 0; m_fext = 0;
            m_faddr = '0; m_xaddr = '0; m_xwide = 0; m_xwr = 0;
            return;
        end
        tk  = m_x2 ? 1'b1 : m_half;
        lst = tk && (m_slot == 5);
        mid = tk && (m_slot == 2);
        ext = !ea || (pc >= 16'h2000);
        if (lst || mid) begin
            m_fext  = ext;
            m_faddr = pc;
        end
        if (lst) begin
            if (!m_kind && req) begin
                m_kind = 1; m_xaddr = xa; m_xwide = wide; m_xwr = wr;
            end else begin
                m_kind = 0;
            end
        end
        nh = m_x2 ? 1'b0 : !m_half;
        if (lst) m_x2 = x2;
        m_half = nh;
        if (tk) m_slot = (m_slot == 5) ? 0 : m_slot + 1;
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        chk("R2 R5 ale", int'(ale), int'(e_ale()));
        chk("R4 psen_n", int'(psen_n), int'(e_psen_n()));
        chk("R7 rd_n", int'(rd_n), int'(e_rd_n()));
        chk("R7 wr_n", int'(wr_n), int'(e_wr_n()));
        chk("R8 p2", int'(p2), int'(e_p2()));
        chk("R9 p0_sel", int'(p0_sel), int'(e_sel()));
        chk("R9 p0_addr", int'(p0_addr), int'(e_p0()));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // counts edges of the strobes over a window of clocks
    task automatic count_window(int len, output int ale_rise, output int psen_fall,
                                output int rd_fall, output int psen_low);
        bit pa, pp, pr;
        ale_rise = 0; psen_fall = 0; rd_fall = 0; psen_low = 0;
        pa = ale; pp = psen_n; pr = rd_n;
        for (int i = 0; i < len; i++) begin
            step();
            if (ale && !pa) ale_rise++;
            if (!psen_n && pp) psen_fall++;
            if (!rd_n && pr) rd_fall++;
            if (!psen_n) psen_low++;
            pa = ale; pp = psen_n; pr = rd_n;
        end
    endtask

    initial begin
        int ar, pf, rf, pl;
        logic [31:0] r;
        void'($urandom(32'h1D5E_ED01));
        model_update();

        // R1: outputs held in reset
        for (int i = 0; i < 3; i++) step();
        chk("R1 psen_n in reset", int'(psen_n), 1);
        chk("R1 rd_n in reset", int'(rd_n), 1);
        chk("R1 wr_n in reset", int'(wr_n), 1);
        chk("R1 p0_sel in reset", int'(p0_sel), 0);
        chk("R1 p2 in reset", int'(p2), 8'h5A);
        rst_n = 1'b1;

        // R2: ALE rate in normal mode, all fetches external
        ea = 1'b0;
        for (int i = 0; i < 24; i++) step();
        count_window(60, ar, pf, rf, pl);
        chk("R2 ale edges normal", ar, 10);
        chk("R4 psen edges normal", pf, 10);

        // R2: ALE rate in double-speed mode
        x2 = 1'b1;
        for (int i = 0; i < 24; i++) step();
        count_window(60, ar, pf, rf, pl);
        chk("R2 ale edges x2", ar, 20);

        // R6 R7: held request gives alternating fetch and data cycles
        req = 1'b1; wide = 1'b1; wr = 1'b0; xa = 16'hC3A5;
        for (int i = 0; i < 24; i++) step();
        count_window(60, ar, pf, rf, pl);
        chk("R6 rd strobes in ten cycles", rf, 5);
        chk("R7 psen edges with data", pf, 10);
        chk("R7 ale edges with data", ar, 15);
        req = 1'b0;

        // R3: internal/external boundary at 0x2000 in normal mode
        x2 = 1'b0; ea = 1'b1; pc = 16'h1FFF;
        for (int i = 0; i < 30; i++) step();
        count_window(12, ar, pf, rf, pl);
        chk("R3 psen low at 0x1FFF", pl, 0);
        pc = 16'h2000;
        for (int i = 0; i < 30; i++) step();
        count_window(12, ar, pf, rf, pl);
        chk("R3 psen low at 0x2000", pl, 4);

        // R5: ALE suppressed on internal fetches
        pc = 16'h0100; ale_off = 1'b1;
        for (int i = 0; i < 30; i++) step();
        count_window(24, ar, pf, rf, pl);
        chk("R5 ale suppressed internal", ar, 0);
        ale_off = 1'b0;

        // random mix checked by the model every clock
        for (int n = 0; n < 20000; n++) begin
            r = $urandom();
            if (r[5:0] == 6'd0) x2 = ~x2;
            if (r[9:6] == 4'd0) ea = ~ea;
            if (r[13:10] == 4'd0) ale_off = ~ale_off;
            if (r[16:14] == 3'd0)
                pc = r[17] ? $urandom() : 16'h1FF8 + 16'($urandom_range(0, 15));
            req  = (r[20:18] == 3'd0);
            wide = r[21];
            wr   = r[22];
            xa   = $urandom();
            if (r[26:23] == 4'd0) sfr = $urandom();
            step();
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule